// File: doc/BRIEF.md
# Buffered Input-Capture Timer

This block is a 16-bit free-running up-counter with four input-capture channels and two output-compare registers. Its behaviour is set by one 8-bit control register. Software chooses the counter's clock source: one of three divisions of the system clock, or an external clock. It also picks which edge of each capture input triggers a capture. It can pair capture register C with channel A and capture register D with channel B, so that each of those two channels keeps its last two captured values. In the same paired mode, each compare channel reloads its compare value from the paired register whenever a match occurs.

Software reaches the block through a simple register port. Writes take effect on the clock edge. Reads are combinational on the address. A read strobe on the flag register arms those flags for clearing. Capture inputs and the external clock are asynchronous, and each one passes through a two-flop synchronizer.

Top module: `cap_timer`

## Requirements
- R1: After reset the control register, counter, capture registers, compare registers and flag register all read as zero.
- R2: The control register (address 0) is 8 bits wide and reads back what was written. Bits 7, 6, 5 and 4 pick the edge for inputs A, B, C and D, where 0 means rising and 1 means falling. Bit 3 pairs C with A, bit 2 pairs D with B, and bits 1:0 pick the clock.
- R3: The clock select chooses the tick. Code 00 ticks once every 2 system clocks, 01 once every 8 and 10 once every 32, all taken from a prescaler that runs from reset. Code 11 ticks once per synchronized rising edge of the external clock. Without a tick the counter holds.
- R4: The 16-bit counter (address 2) adds one per tick and wraps from 0xFFFF to 0x0000. The wrap sets the overflow flag, which is bit 6 of the flag register.
- R5: A selected edge on a capture input, after two synchronizer flops, loads the current count into that channel's register (A at 3, B at 4, C at 5, D at 6). It also sets that channel's flag, which is bit 0, 1, 2 or 3.
- R6: While a pair is enabled, a capture on A copies the old value of register A into C in the same cycle that A loads the count. Channel B does the same into D.
- R7: While a pair is enabled, edges on input C (or D) cause no capture and set no flag.
- R8: When the counter reaches the value of compare register A (address 7) or B (address 8), flag bit 4 or 5 is set. If the channel is paired, the same match also copies register C (or D) into that compare register. Registers C and D can be written by software.
- R9: Writing 0 to a flag clears it only if that flag read as 1 in a read of the flag register (address 1) since it was last cleared. A set event in the same cycle as the clear wins.
- R10: The register port always returns the value of the addressed register, with 8-bit and 7-bit registers zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms flags) |
| addr | input | 4 | Register address |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the addressed register |
| capIn | input | 4 | Asynchronous capture inputs A..D (bit 0 = A) |
| extClk | input | 1 | Asynchronous external count clock |

## Verification
On every cycle the assertions check the counter step, hold and wrap, and that a capture strobe loads the count and raises its flag. They also check the shift from A into C in paired mode, the gating of input C, and the compare reload from C. The divide-by-2 and divide-by-8 tick spacing, the control write and the rule that an unarmed flag survives a clear are checked too. Only the bench scenarios can show the synchronizer latency as seen at the pins, the tick counts over whole windows for each clock source, and a value surviving two paired captures. The same holds for the read-then-clear sequence and the full 65536-tick wrap.

// File: rtl/cap_timer_pkg.sv
`timescale 1ns/1ps
package cap_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int FLAG_W = 7;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_FLAG = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_CAPA = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CAPB = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_CAPC = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_CAPD = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_CMPA = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_CMPB = 4'd8;

  // strobes from control to datapath
  typedef struct packed {
    logic       tick;
    logic [3:0] capStb;
    logic       bufA;
    logic       bufB;
  } tmrStb_t;
endpackage

// File: rtl/cap_timer_ctrl.sv
`timescale 1ns/1ps
module cap_timer_ctrl
  import cap_timer_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  input  logic [3:0]        capIn,
  input  logic              extClk,
  output logic [7:0]        ctrlReg,
  output tmrStb_t           stb
);
  localparam int TAP2  = 1;
  localparam int TAP8  = 3;
  localparam int TAP32 = 5;

  logic [PRE_W-1:0] presc;
  logic [2:0]       extSh;
  logic [3:0]       hit;
  logic             tick;

  always_ff @(posedge clk) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrEn && addr == ADR_CTRL) ctrlReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presc <= '0;
      extSh <= '0;
    end else begin
      presc <= presc + PRE_W'(1);
      extSh <= {extSh[1:0], extClk};
    end
  end

  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : gSync
      logic [2:0] sh;
      logic       fallSel;
      always_ff @(posedge clk) begin
        if (!rstN) sh <= '0;
        else       sh <= {sh[1:0], capIn[g]};
      end
      assign fallSel = ctrlReg[7-g];
      assign hit[g]  = fallSel ? (~sh[1] & sh[2]) : (sh[1] & ~sh[2]);
    end
  endgenerate

  always_comb begin
    unique case (ctrlReg[1:0])
      2'b00:   tick = &presc[TAP2-1:0];
      2'b01:   tick = &presc[TAP8-1:0];
      2'b10:   tick = &presc[TAP32-1:0];
      default: tick = extSh[1] & ~extSh[2];
    endcase
  end

  always_comb begin
    stb.tick   = tick;
    stb.bufA   = ctrlReg[3];
    stb.bufB   = ctrlReg[2];
    stb.capStb = {hit[3] & ~ctrlReg[2], hit[2] & ~ctrlReg[3], hit[1], hit[0]};
  end

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADR_CTRL) |=> ctrlReg == $past(wrData)); // R2
  AST_DIV2_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[1:0] == 2'b00 && tick) |=> (ctrlReg[1:0] != 2'b00 || !tick)); // R3
  AST_DIV8_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[1:0] == 2'b01 && tick) |=> (ctrlReg[1:0] != 2'b01 || !tick)); // R3
endmodule

// File: rtl/cap_timer_dp.sv
`timescale 1ns/1ps
module cap_timer_dp
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStb_t           stb,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [7:0]        ctrlReg,
  output logic [CNT_W-1:0]  rdData
);
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cntNext;
  logic [CNT_W-1:0]  capR [4];
  logic [CNT_W-1:0]  cmpR [2];
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] armed;
  logic [FLAG_W-1:0] setVec;
  logic [FLAG_W-1:0] clrVec;
  logic              matchA;
  logic              matchB;
  logic              wrap;

  assign cntNext = cnt + CNT_W'(1);
  assign wrap    = stb.tick && (&cnt);
  assign matchA  = stb.tick && (cntNext == cmpR[0]);
  assign matchB  = stb.tick && (cntNext == cmpR[1]);
  assign setVec  = {wrap, matchB, matchA, stb.capStb};
  assign clrVec  = (wrEn && addr == ADR_FLAG) ? (armed & ~wrData[FLAG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (stb.tick) cnt <= cntNext;
  end

  // direct captures A and B
  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gDirect
      always_ff @(posedge clk) begin
        if (!rstN) capR[g] <= '0;
        else if (stb.capStb[g]) capR[g] <= cnt;
      end
    end
  endgenerate

  // C and D: capture, history buffer, or software value
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capR[2] <= '0;
      capR[3] <= '0;
    end else begin
      if (stb.bufA && stb.capStb[0])          capR[2] <= capR[0];
      else if (stb.capStb[2])                 capR[2] <= cnt;
      else if (wrEn && addr == ADR_CAPC)      capR[2] <= wrData;
      if (stb.bufB && stb.capStb[1])          capR[3] <= capR[1];
      else if (stb.capStb[3])                 capR[3] <= cnt;
      else if (wrEn && addr == ADR_CAPD)      capR[3] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpR[0] <= '0;
      cmpR[1] <= '0;
    end else begin
      if (stb.bufA && matchA)                 cmpR[0] <= capR[2];
      else if (wrEn && addr == ADR_CMPA)      cmpR[0] <= wrData;
      if (stb.bufB && matchB)                 cmpR[1] <= capR[3];
      else if (wrEn && addr == ADR_CMPB)      cmpR[1] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags <= '0;
      armed <= '0;
    end else begin
      flags <= (flags & ~clrVec) | setVec;
      if (rdEn && addr == ADR_FLAG) armed <= flags;
      else                          armed <= armed & ~clrVec;
    end
  end

  always_comb begin
    unique case (addr)
      ADR_CTRL: rdData = CNT_W'(ctrlReg);
      ADR_FLAG: rdData = CNT_W'(flags);
      ADR_CNT:  rdData = cnt;
      ADR_CAPA: rdData = capR[0];
      ADR_CAPB: rdData = capR[1];
      ADR_CAPC: rdData = capR[2];
      ADR_CAPD: rdData = capR[3];
      ADR_CMPA: rdData = cmpR[0];
      ADR_CMPB: rdData = cmpR[1];
      default:  rdData = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.tick |=> (cnt - $past(cnt)) == CNT_W'(1)); // R4
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.tick |=> $stable(cnt)); // R3
  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && (&cnt)) |=> (flags[6] && cnt == '0)); // R4
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.capStb[0] |=> (capR[0] == $past(cnt) && flags[0])); // R5
  AST_BUF_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bufA && stb.capStb[0]) |=> capR[2] == $past(capR[0])); // R6
  AST_BUF_GATE: assert property (@(posedge clk) disable iff (!rstN)
    stb.bufB |-> !stb.capStb[3]); // R7
  AST_CMP_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.bufA && matchA) |=> (cmpR[0] == $past(capR[2]) && flags[4])); // R8
  AST_UNARMED_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (flags[0] && !armed[0] && !(rdEn && addr == ADR_FLAG)) |=> flags[0]); // R9
endmodule

// File: rtl/cap_timer.sv
`timescale 1ns/1ps
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [3:0]        addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic [3:0]        capIn,
  input  logic              extClk
);
  tmrStb_t    stb;
  logic [7:0] ctrlReg;

  cap_timer_ctrl #(.PRE_W(PRE_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData[7:0]),
    .capIn(capIn), .extClk(extClk), .ctrlReg(ctrlReg), .stb(stb)
  );

  cap_timer_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .ctrlReg(ctrlReg), .rdData(rdData)
  );
endmodule

// File: tb/test_cap_timer.sv
`timescale 1ns/1ps
module test_cap_timer;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic        rdEn = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wrData = 0;
  logic [15:0] rdData;
  logic [3:0]  capIn = 0;
  logic        extClk = 0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cap_timer i_cap_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .capIn(capIn), .extClk(extClk)
  );

  // ---------------- reference model ----------------
  int mCtrl, mPre, mCnt, mFlags, mArmed;
  int mCap[4];
  int mCmp[2];
  bit s1[4], s2[4], pv[4];
  bit e1, e2, ep;
  int nCap[4];
  int nCmp[2];
  int nCnt, setV, clrV, sel;
  bit tick, bA, bB, ovf, mA, mB;
  bit cs[4];

  function automatic int mRead(int a);
    case (a)
      0: return mCtrl;
      1: return mFlags;
      2: return mCnt;
      3: return mCap[0];
      4: return mCap[1];
      5: return mCap[2];
      6: return mCap[3];
      7: return mCmp[0];
      8: return mCmp[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCtrl = 0; mPre = 0; mCnt = 0; mFlags = 0; mArmed = 0;
      for (int i = 0; i < 4; i++) begin mCap[i] = 0; s1[i] = 0; s2[i] = 0; pv[i] = 0; end
      mCmp[0] = 0; mCmp[1] = 0; e1 = 0; e2 = 0; ep = 0;
    end else begin
      sel = mCtrl & 3;
      case (sel)
        0: tick = (mPre % 2) == 1;
        1: tick = (mPre % 8) == 7;
        2: tick = (mPre % 32) == 31;
        default: tick = e2 && !ep;
      endcase
      bA = ((mCtrl >> 3) & 1) == 1;
      bB = ((mCtrl >> 2) & 1) == 1;
      for (int i = 0; i < 4; i++) begin
        if (((mCtrl >> (7 - i)) & 1) == 1) cs[i] = !s2[i] && pv[i];
        else                               cs[i] = s2[i] && !pv[i];
      end
      if (bA) cs[2] = 0;
      if (bB) cs[3] = 0;
      nCnt = tick ? ((mCnt + 1) % 65536) : mCnt;
      ovf  = tick && mCnt == 65535;
      mA   = tick && nCnt == mCmp[0];
      mB   = tick && nCnt == mCmp[1];
      setV = int'(cs[0]) | (int'(cs[1]) << 1) | (int'(cs[2]) << 2) | (int'(cs[3]) << 3)
           | (int'(mA) << 4) | (int'(mB) << 5) | (int'(ovf) << 6);
      clrV = (wrEn && addr == 1) ? (mArmed & ~int'(wrData) & 'h7F) : 0;
      for (int i = 0; i < 4; i++) nCap[i] = mCap[i];
      if (cs[0]) nCap[0] = mCnt;
      if (cs[1]) nCap[1] = mCnt;
      if (bA && cs[0]) nCap[2] = mCap[0];
      else if (cs[2]) nCap[2] = mCnt;
      else if (wrEn && addr == 5) nCap[2] = wrData;
      if (bB && cs[1]) nCap[3] = mCap[1];
      else if (cs[3]) nCap[3] = mCnt;
      else if (wrEn && addr == 6) nCap[3] = wrData;
      nCmp[0] = mCmp[0]; nCmp[1] = mCmp[1];
      if (bA && mA) nCmp[0] = mCap[2];
      else if (wrEn && addr == 7) nCmp[0] = wrData;
      if (bB && mB) nCmp[1] = mCap[3];
      else if (wrEn && addr == 8) nCmp[1] = wrData;
      if (rdEn && addr == 1) mArmed = mFlags;
      else                   mArmed = mArmed & ~clrV;
      mFlags = (mFlags & ~clrV) | setV;
      if (wrEn && addr == 0) mCtrl = wrData & 'hFF;
      for (int i = 0; i < 4; i++) begin
        mCap[i] = nCap[i];
        pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = capIn[i];
      end
      mCmp[0] = nCmp[0]; mCmp[1] = nCmp[1];
      mCnt = nCnt;
      ep = e2; e2 = e1; e1 = extClk;
      mPre = (mPre + 1) % 32;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R10: every cycle the port must match the model
  always @(negedge clk) begin
    if (rstN && !finished) begin
      #1.5;
      check("R10", int'(rdData), mRead(int'(addr)));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    addr = 4'(a); wrData = 16'(d); wrEn = 1;
    @(negedge clk);
    wrEn = 0;
  endtask

  task automatic peek(input int a, output int v);
    @(negedge clk);
    addr = 4'(a);
    #0.2 v = int'(rdData);
  endtask

  task automatic rdFlags(output int v);
    @(negedge clk);
    addr = 4'd1; rdEn = 1;
    #0.2 v = int'(rdData);
    @(negedge clk);
    rdEn = 0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin(input int ch, input bit val);
    @(negedge clk);
    capIn[ch] = val;
    waitCyc(6);
  endtask

  initial begin
    #760000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, v0, v1, c0, c1, cyc;
    waitCyc(5);
    rstN = 1;
    // R1: reset values at the port
    #0.2;
    for (int a = 0; a < 9; a++) begin
      addr = 4'(a);
      #0.1 check("R1", int'(rdData), 0);
    end

    // R2: control readback and width
    wr(0, 'h3A5);
    peek(0, v); check("R2", v, 'hA5);
    wr(0, 'h00);
    peek(0, v); check("R2", v, 0);

    // R3: tick rates
    peek(2, c0); waitCyc(31); peek(2, c1); check("R3 div2", (c1 - c0) & 'hFFFF, 16);
    wr(0, 'h01);
    peek(2, c0); waitCyc(63); peek(2, c1); check("R3 div8", (c1 - c0) & 'hFFFF, 8);
    wr(0, 'h02);
    peek(2, c0); waitCyc(63); peek(2, c1); check("R3 div32", (c1 - c0) & 'hFFFF, 2);
    wr(0, 'h03);
    peek(2, c0);
    for (int k = 0; k < 10; k++) begin
      extClk = 1; waitCyc(3);
      extClk = 0; waitCyc(3);
    end
    waitCyc(4);
    peek(2, c1); check("R3 ext", (c1 - c0) & 'hFFFF, 10);

    // R5: captures, A rising, B falling, C and D rising, clock /2
    wr(0, 'h40);
    pin(0, 1);
    peek(3, v); check("R5 capA", v, mCap[0]);
    peek(1, v); check("R5 flagA", v & 1, 1);
    pin(1, 1);
    peek(1, v); check("R5 B rising ignored", (v >> 1) & 1, 0);
    pin(1, 0);
    peek(4, v); check("R5 capB", v, mCap[1]);
    peek(1, v); check("R5 flagB", (v >> 1) & 1, 1);
    pin(2, 1); pin(3, 1);
    peek(5, v); check("R5 capC", v, mCap[2]);
    peek(6, v); check("R5 capD", v, mCap[3]);
    peek(1, v); check("R5 flagsCD", (v >> 2) & 3, 3);

    // R9: armed clearing
    wr(1, 0);
    peek(1, v); check("R9 unarmed keep", v & 'hF, 'hF);
    rdFlags(v);
    wr(1, 'h7E);
    peek(1, v); check("R9 clear A", v & 'hF, 'hE);
    pin(0, 0); pin(0, 1);
    peek(1, v); check("R9 reset A", v & 1, 1);
    wr(1, 'h00);
    peek(1, v); check("R9 no reread", v & 1, 1);

    // R6 / R7: paired mode
    wr(0, 'h0C);
    rdFlags(v); wr(1, 0);
    peek(1, v); check("R9 clear all", v & 'hF, 0);
    pin(0, 0); pin(0, 1);
    peek(3, v0);
    waitCyc(10);
    pin(0, 0); pin(0, 1);
    peek(5, v); check("R6 history", v, v0);
    peek(3, v1); check("R6 new", v1, mCap[0]);
    check("R6 differ", int'(v1 != v0), 1);
    pin(1, 0); pin(1, 1);
    peek(4, v0);
    waitCyc(5);
    pin(1, 0); pin(1, 1);
    peek(6, v); check("R6 history B", v, v0);
    peek(5, v0);
    pin(2, 0); pin(2, 1);
    peek(5, v); check("R7 C ignored", v, v0);
    peek(1, v); check("R7 flagC", (v >> 2) & 1, 0);

    // R8: compare with reload in paired A, plain in B
    wr(0, 'h08);
    wr(5, 'h1234);
    peek(2, c0);
    wr(7, (c0 + 40) & 'hFFFF);
    wr(8, (c0 + 45) & 'hFFFF);
    waitCyc(120);
    peek(1, v); check("R8 flags", (v >> 4) & 3, 3);
    peek(7, v); check("R8 reload", v, 'h1234);
    peek(8, v); check("R8 plain", v, (c0 + 45) & 'hFFFF);

    // R4: wrap at /2
    wr(0, 'h00);
    peek(1, v); check("R4 before", (v >> 6) & 1, 0);
    peek(2, c0);
    cyc = (65536 - c0) * 2 + 6;
    waitCyc(cyc);
    peek(1, v); check("R4 ovf", (v >> 6) & 1, 1);
    peek(2, v); check("R4 wrapped", int'(v < 16), 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule